// File: doc/BRIEF.md
# Dual-Agent Doorbell Register Bank

This block lets two processing agents on a chip raise events for each other without a shared payload buffer. It holds three independent physical channels, used for low-priority, high-priority and secure traffic. Each channel owns two 32-bit doorbell words, one for each direction. Each agent reaches the words through its own register port. The two ports see mirrored views: the word an agent rings as its transmit bank is the word the other agent services as its receive bank.

A sender rings a doorbell by writing a one-hot mask to its transmit set register. The receiver sees a level interrupt for that channel. It reads its receive status, handles each pending bit and writes the bits back through its clear register. The sender polls its transmit status and treats the event as consumed once its bit reads zero. Only the clear from the far side returns the bit to zero.

Each port is a request channel (valid, write, address, write data) that is always accepted. A write takes effect at the clock edge where valid is high. A read is answered one cycle later with a read-valid strobe. The port has no ready signal, so the block never applies back-pressure and the requester must accept each response in the cycle it appears. Interrupt pins are plain levels.

Top module: `dbmb_top`

## Requirements
- R1: Byte addresses are 10 bits wide. The channel bases are 0x000 (low priority), 0x020 (high priority) and 0x200 (secure). An agent's receive bank sits at the channel base and its transmit bank at base + 0x100. Within a bank, status is at +0x0, set at +0x8 and clear at +0x10.
- R2: A write to a set register ORs the written mask into the bank's word. A write to a clear register clears the bits that are one in the mask. The new value is readable from the next cycle.
- R3: For every channel, agent A's transmit word is agent B's receive word, and B's transmit word is A's receive word. A sender's bit stays set until a clear removes it.
- R4: a_irq[c] is high exactly while A's receive word of channel c is nonzero, and b_irq[c] likewise for B. Each is a level that changes in the cycle after the write that changes the word.
- R5: If one port sets a bit and the other port clears the same bit of the same word in one cycle, the bit ends up set. Other bits in that clear mask are still cleared.
- R6: Writes to a status offset leave the word unchanged. Reads of set or clear offsets return zero.
- R7: Offset 0x3F8 reads the identification value 0x001BB098. Writes to it have no effect.
- R8: Reads of any other offset return zero. Writes to any other offset change no word and no interrupt.
- R9: Every request with valid high and write low is answered by rvalid high in the next cycle, carrying the data at the request edge. rdata is zero whenever rvalid is low.
- R10: Reset clears every doorbell word, deasserts every interrupt and drops rvalid.
- R11: A write to one channel changes no word and no interrupt of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Agent A request valid |
| a_write | input | 1 | Agent A request is a write |
| a_addr | input | 10 | Agent A byte address |
| a_wdata | input | 32 | Agent A write mask |
| a_rvalid | output | 1 | Agent A read response valid |
| a_rdata | output | 32 | Agent A read data |
| b_valid | input | 1 | Agent B request valid |
| b_write | input | 1 | Agent B request is a write |
| b_addr | input | 10 | Agent B byte address |
| b_wdata | input | 32 | Agent B write mask |
| b_rvalid | output | 1 | Agent B read response valid |
| b_rdata | output | 32 | Agent B read data |
| a_irq | output | 3 | Agent A receive interrupt, one per channel |
| b_irq | output | 3 | Agent B receive interrupt, one per channel |

## Verification
The two functions that can meet in one cycle are a sender ringing a bit through its transmit set register and the receiver clearing that word through its receive clear register. A directed case drives both ports in the same cycle on the same word. Its clear mask holds the rung bit and one more pending bit. The case then requires the rung bit to survive, the other bit to vanish, and the receiver's interrupt to stay high. The random phase drives both ports together every cycle over a small pool of addresses, so same-word collisions recur often. Each result is judged against a bench model that first applies all clears of a cycle and then all sets.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int unsigned OFS_STATUS = 'h000;
  localparam int unsigned OFS_SET    = 'h008;
  localparam int unsigned OFS_CLEAR  = 'h010;
  localparam int unsigned OFS_TXBANK = 'h100;
  localparam int unsigned OFS_IDENT  = 'h3F8;
  localparam logic [31:0] IDENT_WORD = 32'h001B_B098;
  localparam int unsigned MAX_CH     = 3;

  // Channel base offsets follow the fixed software-visible map.
  function automatic int unsigned chan_base(input int unsigned c);
    case (c)
      0:       return 'h000;
      1:       return 'h020;
      default: return 'h200;
    endcase
  endfunction
endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SIDE   = 0,
  localparam int unsigned NW    = 2 * NUM_CH
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic [NW-1:0]     set_en,
  output logic [NW-1:0]     clr_en,
  output logic [NW-1:0]     stat_sel,
  output logic              ident_sel,
  output logic              rd_req
);
  import dbmb_pkg::*;

  logic wr_req;
  assign wr_req = valid & write;
  assign rd_req = valid & ~write;
  assign ident_sel = rd_req && (addr == ADDR_W'(OFS_IDENT));

  // Word index c*2+d: d=0 carries A->B doorbells, d=1 carries B->A.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar t = 0; t < 2; t++) begin : g_bank
      localparam int unsigned DIR = (t == 1) ? SIDE : 1 - SIDE;
      localparam int unsigned IDX = c * 2 + DIR;
      localparam logic [ADDR_W-1:0] BASE =
        ADDR_W'(chan_base(c) + ((t == 1) ? OFS_TXBANK : 0));
      assign set_en[IDX]   = wr_req && (addr == BASE + ADDR_W'(OFS_SET));
      assign clr_en[IDX]   = wr_req && (addr == BASE + ADDR_W'(OFS_CLEAR));
      assign stat_sel[IDX] = rd_req && (addr == BASE + ADDR_W'(OFS_STATUS));
    end
  end
endmodule

// File: rtl/dbmb_word.sv
module dbmb_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_a,
  input  logic [W-1:0] clr_a,
  input  logic [W-1:0] set_b,
  input  logic [W-1:0] clr_b,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // Clears apply first, sets last: a set always survives a clash.
  always_comb nxt = (q & ~(clr_a | clr_b)) | set_a | set_b;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dbmb_readback.sv
module dbmb_readback #(
  parameter int unsigned W      = 32,
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned NW    = 2 * NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic [NW-1:0]         stat_sel,
  input  logic                  ident_sel,
  input  logic [NW-1:0][W-1:0]  words,
  output logic                  rvalid,
  output logic [W-1:0]          rdata
);
  import dbmb_pkg::*;

  logic [W-1:0] sel_val;

  always_comb begin
    sel_val = ident_sel ? W'(IDENT_WORD) : '0;
    for (int k = 0; k < NW; k++) begin
      if (stat_sel[k]) sel_val = sel_val | words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_req ? sel_val : '0;
    end
  end
endmodule

// File: rtl/dbmb_top.sv
module dbmb_top #(
  parameter int unsigned DB_BITS = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_CH  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_valid,
  input  logic               a_write,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [DB_BITS-1:0] a_wdata,
  output logic               a_rvalid,
  output logic [DB_BITS-1:0] a_rdata,
  input  logic               b_valid,
  input  logic               b_write,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [DB_BITS-1:0] b_wdata,
  output logic               b_rvalid,
  output logic [DB_BITS-1:0] b_rdata,
  output logic [NUM_CH-1:0]  a_irq,
  output logic [NUM_CH-1:0]  b_irq
);
  localparam int unsigned NW = 2 * NUM_CH;

  logic [NW-1:0] a_set, a_clr, a_stat, b_set, b_clr, b_stat;
  logic          a_ident, b_ident, a_rd, b_rd;
  logic [NW-1:0][DB_BITS-1:0] words;

  dbmb_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SIDE(0)) u_dec_a (
    .valid(a_valid), .write(a_write), .addr(a_addr),
    .set_en(a_set), .clr_en(a_clr), .stat_sel(a_stat),
    .ident_sel(a_ident), .rd_req(a_rd)
  );

  dbmb_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SIDE(1)) u_dec_b (
    .valid(b_valid), .write(b_write), .addr(b_addr),
    .set_en(b_set), .clr_en(b_clr), .stat_sel(b_stat),
    .ident_sel(b_ident), .rd_req(b_rd)
  );

  for (genvar k = 0; k < NW; k++) begin : g_word
    dbmb_word #(.W(DB_BITS)) u_word (
      .clk(clk), .rst_n(rst_n),
      .set_a(a_set[k] ? a_wdata : '0),
      .clr_a(a_clr[k] ? a_wdata : '0),
      .set_b(b_set[k] ? b_wdata : '0),
      .clr_b(b_clr[k] ? b_wdata : '0),
      .q(words[k])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    assign a_irq[c] = |words[c*2+1];
    assign b_irq[c] = |words[c*2];
  end

  dbmb_readback #(.W(DB_BITS), .NUM_CH(NUM_CH)) u_rb_a (
    .clk(clk), .rst_n(rst_n), .rd_req(a_rd), .stat_sel(a_stat),
    .ident_sel(a_ident), .words(words), .rvalid(a_rvalid), .rdata(a_rdata)
  );

  dbmb_readback #(.W(DB_BITS), .NUM_CH(NUM_CH)) u_rb_b (
    .clk(clk), .rst_n(rst_n), .rd_req(b_rd), .stat_sel(b_stat),
    .ident_sel(b_ident), .words(words), .rvalid(b_rvalid), .rdata(b_rdata)
  );
endmodule

// File: rtl/dbmb_checker.sv
module dbmb_checker #(
  parameter int unsigned DB_BITS = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_CH  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_valid,
  input logic               a_write,
  input logic [ADDR_W-1:0]  a_addr,
  input logic [DB_BITS-1:0] a_wdata,
  input logic               a_rvalid,
  input logic [DB_BITS-1:0] a_rdata,
  input logic               b_valid,
  input logic               b_write,
  input logic [ADDR_W-1:0]  b_addr,
  input logic               b_rvalid,
  input logic [DB_BITS-1:0] b_rdata,
  input logic [NUM_CH-1:0]  a_irq,
  input logic [NUM_CH-1:0]  b_irq
);
  import dbmb_pkg::*;

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  always_ff @(posedge clk) begin
    if (was_rst == 1'b1)
      AST_RESET_QUIET: assert (a_irq == '0 && b_irq == '0 && !a_rvalid && !b_rvalid); // R10
  end

  AST_A_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_write) |=> a_rvalid); // R9
  AST_B_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_write) |=> b_rvalid); // R9
  AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rvalid |-> (a_rdata == '0)); // R9
  AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rvalid |-> (b_rdata == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_write && a_addr == ADDR_W'(OFS_TXBANK + OFS_SET) && a_wdata != '0)
      |=> b_irq[0]); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(a_valid && a_write) && !(b_valid && b_write))
      |=> ($stable(a_irq) && $stable(b_irq))); // R4
  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_write && a_addr == ADDR_W'(OFS_IDENT))
      |=> (a_rdata == DB_BITS'(IDENT_WORD))); // R7
endmodule

bind dbmb_top dbmb_checker #(.DB_BITS(DB_BITS), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
  .a_rvalid(a_rvalid), .a_rdata(a_rdata),
  .b_valid(b_valid), .b_write(b_write), .b_addr(b_addr),
  .b_rvalid(b_rvalid), .b_rdata(b_rdata),
  .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/sim_dbmb_top.sv
`timescale 1ns/1ps
module sim_dbmb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 0, a_write = 0, b_valid = 0, b_write = 0;
  logic [9:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic        a_rvalid, b_rvalid;
  logic [31:0] a_rdata, b_rdata;
  logic [2:0]  a_irq, b_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] m [3][2];   // [channel][0: A->B, 1: B->A]

  always #5 clk = ~clk;

  dbmb_top u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_valid(b_valid), .b_write(b_write), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata),
    .a_irq(a_irq), .b_irq(b_irq)
  );

  function automatic int unsigned base_of(int c);
    return (c == 0) ? 'h000 : (c == 1) ? 'h020 : 'h200;
  endfunction

  // Returns 1 when addr hits a bank register; g: 0 status, 1 set, 2 clear.
  function automatic bit decode(input int port, input logic [9:0] addr,
                                output int c, output int d, output int g);
    c = 0; d = 0; g = 0;
    for (int cc = 0; cc < 3; cc++)
      for (int t = 0; t < 2; t++)
        for (int gg = 0; gg < 3; gg++)
          if (addr == 10'(base_of(cc) + t * 'h100 + gg * 8)) begin
            c = cc; d = (t == 1) ? port : 1 - port; g = gg;
            return 1'b1;
          end
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_read(input int port, input logic [9:0] addr);
    int c, d, g;
    if (addr == 10'h3F8) return 32'h001B_B098;
    if (decode(port, addr, c, d, g) && g == 0) return m[c][d];
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input bit av, input bit aw, input logic [9:0] aa, input logic [31:0] ad,
                      input bit bv, input bit bw, input logic [9:0] ba, input logic [31:0] bd);
    logic [31:0] ea, eb;
    logic [31:0] setm [3][2];
    logic [31:0] clrm [3][2];
    logic [2:0]  eia, eib;
    int c, d, g;
    ea = (av && !aw) ? model_read(0, aa) : 32'h0;
    eb = (bv && !bw) ? model_read(1, ba) : 32'h0;
    for (int i = 0; i < 3; i++) for (int j = 0; j < 2; j++) begin
      setm[i][j] = 0; clrm[i][j] = 0;
    end
    if (av && aw && decode(0, aa, c, d, g)) begin
      if (g == 1) setm[c][d] |= ad;
      if (g == 2) clrm[c][d] |= ad;
    end
    if (bv && bw && decode(1, ba, c, d, g)) begin
      if (g == 1) setm[c][d] |= bd;
      if (g == 2) clrm[c][d] |= bd;
    end
    for (int i = 0; i < 3; i++) for (int j = 0; j < 2; j++)
      m[i][j] = (m[i][j] & ~clrm[i][j]) | setm[i][j];
    a_valid = av; a_write = aw; a_addr = aa; a_wdata = ad;
    b_valid = bv; b_write = bw; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    for (int i = 0; i < 3; i++) begin
      eia[i] = |m[i][1];
      eib[i] = |m[i][0];
    end
    check(a_rvalid == (av && !aw), {req, " a_rvalid"}, 32'(a_rvalid), 32'(av && !aw));
    check(b_rvalid == (bv && !bw), {req, " b_rvalid"}, 32'(b_rvalid), 32'(bv && !bw));
    check(a_rdata == ea, {req, " a_rdata"}, a_rdata, ea);
    check(b_rdata == eb, {req, " b_rdata"}, b_rdata, eb);
    check(a_irq == eia, {req, " a_irq"}, 32'(a_irq), 32'(eia));
    check(b_irq == eib, {req, " b_irq"}, 32'(b_irq), 32'(eib));
  endtask

  task automatic rd_a(input string req, input logic [9:0] aa);
    step(req, 1, 0, aa, 0, 0, 0, 0, 0);
  endtask
  task automatic rd_b(input string req, input logic [9:0] ba);
    step(req, 0, 0, 0, 0, 1, 0, ba, 0);
  endtask
  task automatic wr_a(input string req, input logic [9:0] aa, input logic [31:0] ad);
    step(req, 1, 1, aa, ad, 0, 0, 0, 0);
  endtask
  task automatic wr_b(input string req, input logic [9:0] ba, input logic [31:0] bd);
    step(req, 0, 0, 0, 0, 1, 1, ba, bd);
  endtask

  function automatic logic [9:0] pick_addr(input int unsigned r);
    int unsigned s;
    s = r % 22;
    if (s < 18) return 10'(base_of(s / 6) + ((s / 3) % 2) * 'h100 + (s % 3) * 8);
    case (s)
      18: return 10'h3F8;
      19: return 10'h004;
      20: return 10'h118;
      default: return 10'h040;
    endcase
  endfunction

  function automatic logic [31:0] pick_mask(input int unsigned r);
    if (r[3:0] == 0) return $urandom;
    return 32'h1 << (r[8:4] & 5'h7);
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) for (int j = 0; j < 2; j++) m[i][j] = 0;
    rst_n = 1;
  endtask

  initial begin
    #2_000_000ns;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) for (int j = 0; j < 2; j++) m[i][j] = 0;
    @(negedge clk);
    do_reset();
    // R10: everything idle after reset
    check(a_irq == 0 && b_irq == 0, "R10 irq after reset", 32'({a_irq, b_irq}), 0);
    check(!a_rvalid && !b_rvalid, "R10 rvalid after reset", 32'({a_rvalid, b_rvalid}), 0);
    rd_a("R10", 10'h100);
    rd_b("R10", 10'h300);
    // R2 set then clear on A transmit, channel 0
    wr_a("R2", 10'h108, 32'h5);
    rd_a("R2", 10'h100);
    wr_a("R2", 10'h110, 32'h1);
    rd_a("R2", 10'h100);
    // R3 / R4: B sees it on its receive bank and interrupt
    rd_b("R3", 10'h000);
    check(b_irq[0] && !a_irq[0], "R4 b_irq level", 32'({a_irq, b_irq}), 32'h1);
    // R1: secure channel from B transmit to A receive, top bit
    wr_b("R1", 10'h308, 32'h8000_0000);
    rd_a("R1", 10'h200);
    // R11: neighbouring channels untouched
    rd_a("R11", 10'h020);
    rd_b("R11", 10'h020);
    // R6: status writes ignored, set/clear read zero
    wr_a("R6", 10'h100, 32'hFFFF_FFFF);
    rd_a("R6", 10'h100);
    rd_a("R6", 10'h108);
    rd_b("R6", 10'h010);
    // R5: A sets bit 3 while B clears bits 3 and 2 of the same word
    step("R5", 1, 1, 10'h108, 32'h8, 1, 1, 10'h010, 32'hC);
    rd_b("R5", 10'h000);
    check(b_irq[0] == 1'b1, "R5 irq held", 32'(b_irq[0]), 1);
    // R3 completion: sender bit holds until receiver clears
    wr_a("R3", 10'h128, 32'h2);
    rd_a("R3", 10'h120);
    wr_b("R3", 10'h030, 32'h2);
    rd_a("R3", 10'h120);
    // R4: interrupt falls once receive word is empty
    wr_a("R4", 10'h110, 32'hFFFF_FFFF);
    wr_b("R4", 10'h210, 32'hFFFF_FFFF);
    // R7: identification value, write ignored
    rd_b("R7", 10'h3F8);
    wr_a("R7", 10'h3F8, 32'hFFFF_FFFF);
    rd_a("R7", 10'h3F8);
    // R8: unmapped offsets
    wr_a("R8", 10'h118, 32'hFFFF_FFFF);
    wr_b("R8", 10'h040, 32'hFFFF_FFFF);
    rd_a("R8", 10'h004);
    rd_b("R8", 10'h118);
    // R9: back-to-back reads
    rd_a("R9", 10'h000);
    rd_a("R9", 10'h3F8);
    // Random mixed traffic from both agents
    for (int n = 0; n < 1500; n++) begin
      int unsigned r1, r2;
      r1 = $urandom; r2 = $urandom;
      step("R2/R3/R5/R9 random",
           r1[20], r1[21], pick_addr(r1 >> 22), pick_mask($urandom),
           r2[20], r2[21], pick_addr(r2 >> 22), pick_mask($urandom));
    end
    // R10: reset in the middle of activity
    wr_a("R10", 10'h108, 32'hF0);
    wr_b("R10", 10'h128, 32'h3);
    do_reset();
    check(a_irq == 0 && b_irq == 0, "R10 irq after mid reset", 32'({a_irq, b_irq}), 0);
    rd_b("R10", 10'h000);
    rd_a("R10", 10'h020);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule